// File: doc/BRIEF.md
# Data-Processing Operand Shifter

This block forms the second ALU operand of a 32-bit processor's data-processing instructions, together with the carry that the shifter produces. It reads the instruction word and picks one of three forms:

- an 8-bit constant rotated by an even count;
- the second-operand register value shifted by a 5-bit amount taken from the instruction;
- that register value shifted by the low byte of a second register.

A zero amount in the instruction field is given a special meaning for each shift type. It means a shift by 32 for the right shifts, and a one-bit rotate through the carry for the rotate.

Register reads, the ALU and flag writeback are outside the block. The caller supplies three inputs: the register value, the low byte of the amount register and the current carry flag. The logic is combinational. A parameter adds one output register stage, which is on by default. With that stage present, results appear one clock after the inputs and are cleared to zero by reset.

Top module: `operand_shifter`

## Requirements
- R1: When instruction bit 25 is 1, the operand is bits [7:0], zero-extended and rotated right by twice the value in bits [11:8]. The carry-out is the incoming carry when that count is 0, and bit 31 of the result otherwise.
- R2: When bit 25 is 0, the value is the register operand. Bits [6:5] select the shift type: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For an amount n from 1 to 31, the carry-out is the last bit shifted out, which is the bit at position 32-n for a left shift and n-1 for the right shifts and the rotate.
- R3: When bit 4 is 0, the amount is bits [11:7]. A logical left shift with a field of 0 passes the value through, and the carry-out equals the incoming carry.
- R4: When bit 4 is 0, a logical or arithmetic right shift with a field of 0 shifts by 32.
- R5: When bit 4 is 0, a rotate with a field of 0 gives {carry-in, value[31:1]}, and the carry-out is value bit 0.
- R6: When bit 4 is 1, the amount is the low 8 bits of the amount register (0 to 255). An amount of 0 leaves both the value and the carry unchanged.
- R7: A logical shift by exactly 32 gives 0, with carry-out equal to bit 0 for a left shift and bit 31 for a right shift. A logical shift by more than 32 gives 0 with carry-out 0.
- R8: An arithmetic right shift by 32 or more fills every bit with bit 31, and the carry-out equals bit 31.
- R9: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged, with carry-out equal to bit 31.
- R10: The undefined flag is 1 exactly when bit 25 is 0, bit 4 is 1 and bit 7 is 1.
- R11: With the output stage present, the outputs show the result for the inputs sampled at the previous rising clock edge. While the active-low reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Data-processing instruction word |
| rmVal | input | 32 | Value of the second-operand register |
| rsByte | input | 8 | Low byte of the shift-amount register |
| carryIn | input | 1 | Current carry flag |
| shOperand | output | 32 | Shifted second operand |
| shCarry | output | 1 | Shifter carry-out |
| badEncoding | output | 1 | Undefined register-amount encoding |

## Verification
The assertions assume that the register value, amount byte, carry and instruction change only between clock edges and are held steady across the edge that captures them. They also assume that, when the output stage is present, each result is checked against the inputs captured one edge earlier. The bench drives every input on the falling edge and samples on the next falling edge, so each vector stays stable across its capture edge. Reset is held for several edges before any vector is applied, so no property relates outputs to inputs captured during reset.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int OPND_W = 32;
  localparam int AMT_W  = 8;
  localparam int IMM_W  = 8;
  localparam int SH_W   = $clog2(OPND_W) + 1;

  localparam int IMM_SEL_BIT = 25;
  localparam int BY_REG_BIT  = 4;
  localparam int BAD_BIT     = 7;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shKind_e;

  typedef struct packed {
    shKind_e          kind;
    logic [AMT_W-1:0] amt;
    logic [IMM_W-1:0] imm8;
    logic             useImm;
    logic             rrx;
  } shCtl_t;
endpackage

// File: rtl/opsh_ctl.sv
module opsh_ctl
  import opsh_pkg::*;
(
  input  logic [OPND_W-1:0] instr,
  input  logic [AMT_W-1:0]  rsByte,
  output shCtl_t            ctl,
  output logic              badEnc
);
  logic            useImm;
  logic            byReg;
  logic [SH_W-1:0] immAmt;
  logic [4:0]      amtField;

  assign useImm   = instr[IMM_SEL_BIT];
  assign byReg    = ~useImm & instr[BY_REG_BIT];
  assign badEnc   = byReg & instr[BAD_BIT];
  assign amtField = instr[11:7];

  always_comb begin
    ctl        = '0;
    ctl.imm8   = instr[7:0];
    ctl.useImm = useImm;
    immAmt     = '0;
    if (useImm) begin
      ctl.kind = SH_ROR;
      immAmt   = {1'b0, instr[11:8], 1'b0};
    end else begin
      ctl.kind = shKind_e'(instr[6:5]);
      immAmt   = {1'b0, amtField};
      if (!byReg && amtField == 5'd0) begin
        unique case (ctl.kind)
          SH_LSR, SH_ASR: immAmt = SH_W'(OPND_W);
          SH_ROR:         ctl.rrx = 1'b1;
          default:        immAmt = '0;
        endcase
      end
    end
    ctl.amt = byReg ? rsByte : AMT_W'(immAmt);
  end
endmodule

// File: rtl/opsh_dp.sv
module opsh_dp
  import opsh_pkg::*;
(
  input  shCtl_t            ctl,
  input  logic [OPND_W-1:0] rmVal,
  input  logic              carryIn,
  output logic [OPND_W-1:0] result,
  output logic              carryOut
);
  localparam int LG = $clog2(OPND_W);

  logic [OPND_W-1:0]   val;
  logic [2*OPND_W-1:0] dbl;
  logic [2*OPND_W-1:0] rotd;
  logic [OPND_W:0]     ext;
  logic [LG-1:0]       rot;

  always_comb begin
    val      = ctl.useImm ? OPND_W'(ctl.imm8) : rmVal;
    dbl      = {val, val};
    rot      = ctl.amt[LG-1:0];
    rotd     = dbl >> rot;
    ext      = '0;
    result   = val;
    carryOut = carryIn;
    if (ctl.rrx) begin
      result   = {carryIn, val[OPND_W-1:1]};
      carryOut = val[0];
    end else if (ctl.amt != '0) begin
      unique case (ctl.kind)
        SH_LSL: begin
          ext = {1'b0, val} << ctl.amt;
          {carryOut, result} = ext;
        end
        SH_LSR: begin
          ext = {val, 1'b0} >> ctl.amt;
          {result, carryOut} = ext;
        end
        SH_ASR: begin
          ext = $signed({val, 1'b0}) >>> ctl.amt;
          {result, carryOut} = ext;
        end
        default: begin
          result   = rotd[OPND_W-1:0];
          carryOut = rotd[OPND_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPND_W-1:0] instr,
  input  logic [OPND_W-1:0] rmVal,
  input  logic [AMT_W-1:0]  rsByte,
  input  logic              carryIn,
  output logic [OPND_W-1:0] shOperand,
  output logic              shCarry,
  output logic              badEncoding
);
  shCtl_t            ctl;
  logic              badComb;
  logic [OPND_W-1:0] resComb;
  logic              carryComb;

  opsh_ctl u_ctl (
    .instr (instr),
    .rsByte(rsByte),
    .ctl   (ctl),
    .badEnc(badComb)
  );

  opsh_dp u_dp (
    .ctl     (ctl),
    .rmVal   (rmVal),
    .carryIn (carryIn),
    .result  (resComb),
    .carryOut(carryComb)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shOperand   <= '0;
          shCarry     <= 1'b0;
          badEncoding <= 1'b0;
        end else begin
          shOperand   <= resComb;
          shCarry     <= carryComb;
          badEncoding <= badComb;
        end
      end
    end else begin : g_comb
      assign shOperand   = resComb;
      assign shCarry     = carryComb;
      assign badEncoding = badComb;
    end
  endgenerate
endmodule

// File: rtl/opsh_chk.sv
module opsh_chk
  import opsh_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [OPND_W-1:0] instr,
  input logic [OPND_W-1:0] rmVal,
  input logic [AMT_W-1:0]  rsByte,
  input logic              carryIn,
  input logic [OPND_W-1:0] shOperand,
  input logic              shCarry,
  input logic              badEncoding
);
  logic [OPND_W-1:0] sInstr, sRm;
  logic [AMT_W-1:0]  sRs;
  logic              sCin, sValid;

  generate
    if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sInstr <= '0; sRm <= '0; sRs <= '0; sCin <= 1'b0; sValid <= 1'b0;
        end else begin
          sInstr <= instr; sRm <= rmVal; sRs <= rsByte; sCin <= carryIn; sValid <= 1'b1;
        end
      end
    end else begin : g_now
      assign sInstr = instr;
      assign sRm    = rmVal;
      assign sRs    = rsByte;
      assign sCin   = carryIn;
      assign sValid = 1'b1;
    end
  endgenerate

  // R10
  undef_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    sValid |-> badEncoding == (!sInstr[25] && sInstr[4] && sInstr[7]));

  // R3
  lsl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !sInstr[25] && !sInstr[4] && sInstr[6:5] == 2'b00 && sInstr[11:7] == 5'd0)
    |-> (shOperand == sRm && shCarry == sCin));

  // R5
  rrx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !sInstr[25] && !sInstr[4] && sInstr[6:5] == 2'b11 && sInstr[11:7] == 5'd0)
    |-> (shOperand == {sCin, sRm[OPND_W-1:1]} && shCarry == sRm[0]));

  // R4
  lsr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !sInstr[25] && !sInstr[4] && sInstr[6:5] == 2'b01 && sInstr[11:7] == 5'd0)
    |-> (shOperand == '0 && shCarry == sRm[OPND_W-1]));

  // R6
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !sInstr[25] && sInstr[4] && sRs == '0)
    |-> (shOperand == sRm && shCarry == sCin));

  // R1
  imm_norot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sInstr[25] && sInstr[11:8] == 4'd0)
    |-> (shOperand == OPND_W'(sInstr[7:0]) && shCarry == sCin));
endmodule

bind operand_shifter opsh_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_operand_shifter.sv
module test_operand_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] rm;
    logic [7:0]  rs;
    logic        cin;
    logic [31:0] expOp;
    logic        expC;
    logic        expUnd;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0200_04FF, 32'h0, 8'd0, 1'b0, 32'hFF00_0000, 1'b1, 1'b0},       // R1 rotate by 8
    '{32'h0200_0080, 32'h0, 8'd0, 1'b1, 32'h0000_0080, 1'b1, 1'b0},       // R1 count 0
    '{32'h0000_0200, 32'hF000_0001, 8'd0, 1'b0, 32'h0000_0010, 1'b1, 1'b0}, // R2 lsl 4
    '{32'h0000_0020, 32'h8000_0000, 8'd0, 1'b0, 32'h0, 1'b1, 1'b0},       // R4 lsr 32
    '{32'h0000_0040, 32'h8000_0000, 8'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 asr 32
    '{32'h0000_0060, 32'h0000_0003, 8'd0, 1'b1, 32'h8000_0001, 1'b1, 1'b0}, // R5 rrx
    '{32'h0000_0010, 32'hFFFF_FFFF, 8'd33, 1'b1, 32'h0, 1'b0, 1'b0},      // R7 lsl 33
    '{32'h0000_0070, 32'h8000_0000, 8'd64, 1'b0, 32'h8000_0000, 1'b1, 1'b0}, // R9 ror 64
    '{32'h0000_0030, 32'h0000_1234, 8'd0, 1'b1, 32'h0000_1234, 1'b1, 1'b0}, // R6 amount 0
    '{32'h0000_0090, 32'h0000_0005, 8'd0, 1'b0, 32'h0000_0005, 1'b0, 1'b1}, // R10 undefined
    '{32'h0000_00A0, 32'h0000_0003, 8'd0, 1'b0, 32'h0000_0001, 1'b1, 1'b0}, // R2 lsr 1
    '{32'h0000_0050, 32'h7FFF_FFFF, 8'd200, 1'b1, 32'h0, 1'b0, 1'b0}      // R8 asr 200
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rmVal = '0;
  logic [7:0]  rsByte = '0;
  logic        carryIn = 1'b0;
  logic [31:0] shOperand;
  logic        shCarry;
  logic        badEncoding;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  operand_shifter i_operand_shifter (
    .clk(clk), .rstN(rstN), .instr(instr), .rmVal(rmVal), .rsByte(rsByte),
    .carryIn(carryIn), .shOperand(shOperand), .shCarry(shCarry), .badEncoding(badEncoding)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: shift one bit at a time, carry is the last bit moved out.
  function automatic logic [32:0] refShift(input logic [1:0] kind, input logic [31:0] v,
                                           input int n, input logic c);
    logic [31:0] x = v;
    logic        cy = c;
    for (int i = 0; i < n; i++) begin
      case (kind)
        2'b00: begin cy = x[31]; x = {x[30:0], 1'b0}; end
        2'b01: begin cy = x[0];  x = {1'b0, x[31:1]}; end
        2'b10: begin cy = x[0];  x = {x[31], x[31:1]}; end
        default: begin cy = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {cy, x};
  endfunction

  function automatic logic [32:0] refModel(input logic [31:0] ins, input logic [31:0] v,
                                           input logic [7:0] rs, input logic c);
    int n;
    if (ins[25]) return refShift(2'b11, {24'h0, ins[7:0]}, 2 * int'(ins[11:8]), c);
    if (ins[4]) return refShift(ins[6:5], v, int'(rs), c);
    n = int'(ins[11:7]);
    if (n == 0 && ins[6:5] == 2'b11) return {v[0], c, v[31:1]};
    if (n == 0 && ins[6:5] != 2'b00) n = 32;
    return refShift(ins[6:5], v, n, c);
  endfunction

  task automatic check(input string req, input logic [31:0] eOp, input logic eC, input logic eU);
    checks++;
    if (shOperand !== eOp || shCarry !== eC || badEncoding !== eU) begin
      fails++;
      $display("FAIL %s instr=%h: got op=%h c=%b und=%b, expected op=%h c=%b und=%b",
               req, instr, shOperand, shCarry, badEncoding, eOp, eC, eU);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] v, input logic [7:0] rs,
                       input logic c);
    @(negedge clk);
    instr = ins; rmVal = v; rsByte = rs; carryIn = c;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [32:0] r;
    logic [31:0] ins;
    logic [31:0] pats [2];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h5A3C_96E7;
    // R11: reset state, even with live inputs
    instr = 32'h0200_04FF; rmVal = 32'hFFFF_FFFF; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset", 32'h0, 1'b0, 1'b0);
    rstN = 1'b1;
    // Table of directed vectors
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].instr, VECS[i].rm, VECS[i].rs, VECS[i].cin);
      check("R1-table", VECS[i].expOp, VECS[i].expC, VECS[i].expUnd);
    end
    // R11: result follows one edge after the inputs change
    @(negedge clk);
    instr = 32'h0000_0200; rmVal = 32'h1; rsByte = 8'd0; carryIn = 1'b0;
    @(posedge clk); #1;
    check("R11 latency", 32'h0000_0010, 1'b0, 1'b0);
    // R6 R7 R8 R9 R10 R2: every type and every register amount 0..255
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 256; a++) begin
        for (int p = 0; p < 2; p++) begin
          ins = 32'h0000_0010 | (32'(k) << 5) | ((a % 3 == 0) ? 32'h80 : 32'h0);
          apply(ins, pats[p], 8'(a), p[0]);
          r = refModel(ins, pats[p], 8'(a), p[0]);
          check("R6_R7_R8_R9_R10 reg", r[31:0], r[32], ins[7]);
        end
      end
    end
    // R2 R3 R4 R5: every type and every immediate amount
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 32; a++) begin
        for (int p = 0; p < 2; p++) begin
          ins = (32'(a) << 7) | (32'(k) << 5) | 32'h80_0000;
          apply(ins, pats[p], 8'hFF, ~p[0]);
          r = refModel(ins, pats[p], 8'hFF, ~p[0]);
          check("R2_R3_R4_R5 imm amount", r[31:0], r[32], 1'b0);
        end
      end
    end
    // R1: every even rotation of two constants
    for (int rot = 0; rot < 16; rot++) begin
      for (int p = 0; p < 2; p++) begin
        ins = 32'h0200_0000 | (32'(rot) << 8) | (p[0] ? 32'h81 : 32'h3C) | 32'h90;
        apply(ins, 32'hFFFF_FFFF, 8'd7, p[0]);
        r = refModel(ins, 32'hFFFF_FFFF, 8'd7, p[0]);
        check("R1 imm rotate", r[31:0], r[32], 1'b0);
      end
    end
    // R11: reset clears outputs
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 reset again", 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule